// File: doc/BRIEF.md
# Three-Stage Instruction Pointer Sequencer

This block keeps the three instruction pointers of a pipelined processor: the one being fetched, the one waiting to issue and the one in execution. Each pointer is a word address with two flag bits packed into its two low bits: bit 0 marks the pointer valid and bit 1 records that the fetch at that address failed. Each cycle the pointers shift one stage toward execution. A fetch fault rides along with its pointer and becomes an instruction-fault exception only when that pointer reaches execution while valid.

The block also carries out exception entry, interrupt acceptance, branch redirects and return from exception. It holds the processor status bits, the saved status, a scoreboard word and a set of shadow registers. The shadow registers track the live pointers and scoreboard until the freeze bit stops them, so a handler can see where the pipeline was when the exception was taken. Instruction decode, the register file and memory sit outside the block. They supply exception requests, scoreboard updates, redirect targets and the vector base.

Top module: `ip_sequencer`

## Requirements
- R1: Reset sets the fetch pointer to address 0 with valid set (value 0x1), clears the next and execute pointers, the saved status, the scoreboard and all shadows, and sets the status to supervisor only (0x8).
- R2: Each cycle without an event, execute takes next, next takes fetch, and fetch moves to address+4 with its error bit (bit 1) cleared and its valid bit (bit 0) kept.
- R3: While the freeze bit (status bit 0) is clear, the shadow fetch, next, execute and scoreboard registers take the live values each cycle. While it is set they hold.
- R4: A fetch fault on a valid fetch pointer sets bit 1 of that pointer as it moves to next. `ifault_o` is high while the execute pointer is valid with bit 1 set. The following edge enters exception vector 1, and this outranks any other request in that cycle.
- R5: Exception entry sets status bits 3 (supervisor), 2 (FPU off), 1 (interrupts off) and 0 (freeze), copies the old status to the saved status, clears the scoreboard, and clears the valid bits of execute and next. Fetch becomes (vbr with its low VEC_W+3 bits cleared) | vector<<3 | 1.
- R6: An interrupt request enters vector 3 only while status bit 1 is clear. Otherwise the request has no effect.
- R7: Return from exception in supervisor mode loads the status from the saved status and the scoreboard from its shadow. Next becomes the shadow next with bit 1 cleared, because it is refetched. Fetch becomes the shadow fetch, and execute loses its valid bit.
- R8: Return from exception with status bit 3 clear enters vector 2 instead.
- R9: A redirect loads fetch with the target (low bits replaced by valid). Next takes the old fetch pointer, with its valid bit cleared when `redirect_kill_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_fault_i | input | 1 | Fetch at the current fetch pointer failed |
| irq_i | input | 1 | Interrupt request |
| exc_req_i | input | 1 | Exception request from decode |
| exc_vec_i | input | VEC_W | Vector number of that request |
| rte_i | input | 1 | Return-from-exception command |
| redirect_i | input | 1 | Branch redirect |
| redirect_kill_i | input | 1 | Redirect discards the instruction in next |
| redirect_tgt_i | input | AW | Redirect target address |
| vbr_i | input | AW | Vector base |
| sb_set_i | input | SB_W | Scoreboard bits to set |
| sb_clr_i | input | SB_W | Scoreboard bits to clear |
| fip_o | output | AW | Fetch pointer |
| nip_o | output | AW | Next pointer |
| xip_o | output | AW | Execute pointer |
| sfip_o | output | AW | Shadow fetch pointer |
| snip_o | output | AW | Shadow next pointer |
| sxip_o | output | AW | Shadow execute pointer |
| psr_o | output | 4 | Status: supervisor, FPU off, interrupts off, freeze |
| epsr_o | output | 4 | Saved status |
| sb_o | output | SB_W | Scoreboard |
| ssb_o | output | SB_W | Shadow scoreboard |
| ifault_o | output | 1 | Instruction fault pending in execute |

## Verification
Every pointer, status, scoreboard and shadow result is registered. A stimulus applied in one cycle therefore shows up after the next rising edge. The exception is `ifault_o`, which follows the execute pointer in the same cycle. A fetch fault takes two edges to reach execute and a third to enter the handler. The bench drives inputs just after a falling edge, steps one rising edge, and compares at the following falling edge. Each expected value is counted out edge by edge from reset in every scenario task.

// File: rtl/ip_seq_pkg.sv
package ip_seq_pkg;
   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_ENTER = 2'd1,
      EV_RET   = 2'd2,
      EV_REDIR = 2'd3
   } ev_e;

   localparam int ST_W   = 4;
   localparam int ST_SUP = 3;
   localparam int ST_FPD = 2;
   localparam int ST_IND = 1;
   localparam int ST_FRZ = 0;

   localparam int PTR_VLD = 0;
   localparam int PTR_ERR = 1;
endpackage

// File: rtl/ip_seq_arbiter.sv
module ip_seq_arbiter
   import ip_seq_pkg::*;
#(
   parameter int VEC_W      = 9,
   parameter int IFAULT_VEC = 1,
   parameter int PRIV_VEC   = 2,
   parameter int IRQ_VEC    = 3
) (
   input  logic             x_vld,
   input  logic             x_err,
   input  logic             exc_req,
   input  logic [VEC_W-1:0] exc_vec,
   input  logic             rte,
   input  logic             sup,
   input  logic             int_dis,
   input  logic             irq,
   input  logic             redirect,
   output ev_e              ev,
   output logic [VEC_W-1:0] vec,
   output logic             ifault
);
   localparam logic [VEC_W-1:0] V_IFAULT = VEC_W'(IFAULT_VEC);
   localparam logic [VEC_W-1:0] V_PRIV   = VEC_W'(PRIV_VEC);
   localparam logic [VEC_W-1:0] V_IRQ    = VEC_W'(IRQ_VEC);

   assign ifault = x_vld & x_err;

   // priority: faulted execute, return/privilege, decode request, interrupt, redirect
   always_comb begin
      ev  = EV_NONE;
      vec = '0;
      if (ifault) begin
         ev  = EV_ENTER;
         vec = V_IFAULT;
      end else if (rte) begin
         if (sup) begin
            ev = EV_RET;
         end else begin
            ev  = EV_ENTER;
            vec = V_PRIV;
         end
      end else if (exc_req) begin
         ev  = EV_ENTER;
         vec = exc_vec;
      end else if (irq && !int_dis) begin
         ev  = EV_ENTER;
         vec = V_IRQ;
      end else if (redirect) begin
         ev = EV_REDIR;
      end
   end
endmodule

// File: rtl/ip_seq_shadow.sv
module ip_seq_shadow #(
   parameter int AW    = 32,
   parameter int SB_W  = 32,
   parameter int NPTR  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     freeze,
   input  logic [NPTR-1:0][AW-1:0]  live,
   input  logic [SB_W-1:0]          sb,
   output logic [NPTR-1:0][AW-1:0]  shadow,
   output logic [SB_W-1:0]          ssb
);
   for (genvar i = 0; i < NPTR; i++) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       shadow[i] <= '0;
         else if (!freeze) shadow[i] <= live[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ssb <= '0;
      else if (!freeze) ssb <= sb;
   end
endmodule

// File: rtl/ip_seq_pipe.sv
module ip_seq_pipe
   import ip_seq_pkg::*;
#(
   parameter int AW    = 32,
   parameter int VEC_W = 9,
   parameter int SB_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ev_e              ev,
   input  logic [VEC_W-1:0] vec,
   input  logic [AW-1:0]    vbr,
   input  logic             fetch_fault,
   input  logic             redirect_kill,
   input  logic [AW-1:0]    redirect_tgt,
   input  logic [SB_W-1:0]  sb_set,
   input  logic [SB_W-1:0]  sb_clr,
   input  logic [AW-1:0]    snip_sh,
   input  logic [AW-1:0]    sfip_sh,
   input  logic [SB_W-1:0]  ssb_sh,
   output logic [AW-1:0]    fip,
   output logic [AW-1:0]    nip,
   output logic [AW-1:0]    xip,
   output logic [ST_W-1:0]  psr,
   output logic [ST_W-1:0]  epsr,
   output logic [SB_W-1:0]  sb
);
   localparam logic [AW-1:0]   VBR_KEEP = ~((AW'(1) << (VEC_W + 3)) - AW'(1));
   localparam logic [AW-1:0]   VLD_BIT  = AW'(1) << PTR_VLD;
   localparam logic [AW-1:0]   ERR_BIT  = AW'(1) << PTR_ERR;
   localparam logic [AW-1:0]   FLAGS    = VLD_BIT | ERR_BIT;
   localparam logic [ST_W-1:0] ENTER_SET =
      ST_W'((1 << ST_SUP) | (1 << ST_FPD) | (1 << ST_IND) | (1 << ST_FRZ));
   localparam logic [ST_W-1:0] RESET_ST = ST_W'(1 << ST_SUP);

   logic [AW-1:0] f_eff, f_inc, vec_addr, tgt_ptr;

   always_comb begin
      f_eff = fip;
      if (fetch_fault && fip[PTR_VLD]) f_eff = fip | ERR_BIT;
      f_inc    = ((fip & ~FLAGS) + AW'(4)) | (fip & VLD_BIT);
      vec_addr = (vbr & VBR_KEEP) | (AW'(vec) << 3) | VLD_BIT;
      tgt_ptr  = (redirect_tgt & ~FLAGS) | VLD_BIT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fip  <= VLD_BIT;
         nip  <= '0;
         xip  <= '0;
         psr  <= RESET_ST;
         epsr <= '0;
         sb   <= '0;
      end else begin
         unique case (ev)
            EV_ENTER: begin
               xip  <= nip & ~VLD_BIT;
               nip  <= f_eff & ~VLD_BIT;
               fip  <= vec_addr;
               psr  <= psr | ENTER_SET;
               epsr <= psr;
               sb   <= '0;
            end
            EV_RET: begin
               xip <= nip & ~VLD_BIT;
               nip <= snip_sh & ~ERR_BIT;
               fip <= sfip_sh;
               psr <= epsr;
               sb  <= ssb_sh;
            end
            EV_REDIR: begin
               xip <= nip;
               nip <= redirect_kill ? (f_eff & ~VLD_BIT) : f_eff;
               fip <= tgt_ptr;
               sb  <= (sb | sb_set) & ~sb_clr;
            end
            default: begin
               xip <= nip;
               nip <= f_eff;
               fip <= f_inc;
               sb  <= (sb | sb_set) & ~sb_clr;
            end
         endcase
      end
   end
endmodule

// File: rtl/ip_sequencer.sv
module ip_sequencer
   import ip_seq_pkg::*;
#(
   parameter int AW         = 32,
   parameter int VEC_W      = 9,
   parameter int SB_W       = 32,
   parameter int IFAULT_VEC = 1,
   parameter int PRIV_VEC   = 2,
   parameter int IRQ_VEC    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fetch_fault_i,
   input  logic             irq_i,
   input  logic             exc_req_i,
   input  logic [VEC_W-1:0] exc_vec_i,
   input  logic             rte_i,
   input  logic             redirect_i,
   input  logic             redirect_kill_i,
   input  logic [AW-1:0]    redirect_tgt_i,
   input  logic [AW-1:0]    vbr_i,
   input  logic [SB_W-1:0]  sb_set_i,
   input  logic [SB_W-1:0]  sb_clr_i,
   output logic [AW-1:0]    fip_o,
   output logic [AW-1:0]    nip_o,
   output logic [AW-1:0]    xip_o,
   output logic [AW-1:0]    sfip_o,
   output logic [AW-1:0]    snip_o,
   output logic [AW-1:0]    sxip_o,
   output logic [3:0]       psr_o,
   output logic [3:0]       epsr_o,
   output logic [SB_W-1:0]  sb_o,
   output logic [SB_W-1:0]  ssb_o,
   output logic             ifault_o
);
   localparam int NPTR = 3;

   if (AW < VEC_W + 4) begin : g_bad_aw
      $error("ip_sequencer: AW too small for the vector field");
   end
   if (IFAULT_VEC >= (1 << VEC_W) || PRIV_VEC >= (1 << VEC_W) ||
       IRQ_VEC >= (1 << VEC_W)) begin : g_bad_vec
      $error("ip_sequencer: fixed vector does not fit VEC_W");
   end
   if (ST_W != 4) begin : g_bad_st
      $error("ip_sequencer: status width must be 4");
   end

   ev_e                     ev;
   logic [VEC_W-1:0]        vec;
   logic [NPTR-1:0][AW-1:0] live, shadow;

   ip_seq_arbiter #(
      .VEC_W(VEC_W), .IFAULT_VEC(IFAULT_VEC),
      .PRIV_VEC(PRIV_VEC), .IRQ_VEC(IRQ_VEC)
   ) u_arb (
      .x_vld    (xip_o[PTR_VLD]),
      .x_err    (xip_o[PTR_ERR]),
      .exc_req  (exc_req_i),
      .exc_vec  (exc_vec_i),
      .rte      (rte_i),
      .sup      (psr_o[ST_SUP]),
      .int_dis  (psr_o[ST_IND]),
      .irq      (irq_i),
      .redirect (redirect_i),
      .ev       (ev),
      .vec      (vec),
      .ifault   (ifault_o)
   );

   ip_seq_pipe #(.AW(AW), .VEC_W(VEC_W), .SB_W(SB_W)) u_pipe (
      .clk           (clk),
      .rst_n         (rst_n),
      .ev            (ev),
      .vec           (vec),
      .vbr           (vbr_i),
      .fetch_fault   (fetch_fault_i),
      .redirect_kill (redirect_kill_i),
      .redirect_tgt  (redirect_tgt_i),
      .sb_set        (sb_set_i),
      .sb_clr        (sb_clr_i),
      .snip_sh       (snip_o),
      .sfip_sh       (sfip_o),
      .ssb_sh        (ssb_o),
      .fip           (fip_o),
      .nip           (nip_o),
      .xip           (xip_o),
      .psr           (psr_o),
      .epsr          (epsr_o),
      .sb            (sb_o)
   );

   assign live[0] = xip_o;
   assign live[1] = nip_o;
   assign live[2] = fip_o;

   ip_seq_shadow #(.AW(AW), .SB_W(SB_W), .NPTR(NPTR)) u_shadow (
      .clk    (clk),
      .rst_n  (rst_n),
      .freeze (psr_o[ST_FRZ]),
      .live   (live),
      .sb     (sb_o),
      .shadow (shadow),
      .ssb    (ssb_o)
   );

   assign sxip_o = shadow[0];
   assign snip_o = shadow[1];
   assign sfip_o = shadow[2];
endmodule

// File: rtl/ip_sequencer_chk.sv
module ip_sequencer_chk #(
   parameter int AW   = 32,
   parameter int SB_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq_i,
   input logic            exc_req_i,
   input logic            rte_i,
   input logic            redirect_i,
   input logic [AW-1:0]   fip_o,
   input logic [AW-1:0]   nip_o,
   input logic [AW-1:0]   xip_o,
   input logic [AW-1:0]   sfip_o,
   input logic [AW-1:0]   sxip_o,
   input logic [3:0]      psr_o,
   input logic [SB_W-1:0] sb_o,
   input logic            ifault_o
);
   // R2
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_req_i && !rte_i && !redirect_i && !ifault_o && !(irq_i && !psr_o[1]))
      |=> (xip_o == $past(nip_o)));

   // R3
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psr_o[0] |=> ($stable(sfip_o) && $stable(sxip_o)));

   // R4
   ifault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ifault_o |=> (fip_o[0] && !xip_o[0] && !nip_o[0] && psr_o == 4'hF));

   // R5
   entry_sb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req_i && !rte_i && !ifault_o) |=> (sb_o == '0 && psr_o == 4'hF));

   // R6
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_i && psr_o[1] && !exc_req_i && !rte_i && !ifault_o) |=> $stable(psr_o));

   // R8
   priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rte_i && !psr_o[3] && !ifault_o) |=> (psr_o[3] && psr_o[0]));
endmodule

bind ip_sequencer ip_sequencer_chk #(.AW(AW), .SB_W(SB_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_i      (irq_i),
   .exc_req_i  (exc_req_i),
   .rte_i      (rte_i),
   .redirect_i (redirect_i),
   .fip_o      (fip_o),
   .nip_o      (nip_o),
   .xip_o      (xip_o),
   .sfip_o     (sfip_o),
   .sxip_o     (sxip_o),
   .psr_o      (psr_o),
   .sb_o       (sb_o),
   .ifault_o   (ifault_o)
);

// File: tb/ip_sequencer_test.sv
`timescale 1ns/1ps
module ip_sequencer_test;
   localparam int AW = 32, VEC_W = 9, SB_W = 32;
   localparam logic [31:0] VBR = 32'h0002_0000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic fetch_fault_i, irq_i, exc_req_i, rte_i, redirect_i, redirect_kill_i;
   logic [VEC_W-1:0] exc_vec_i;
   logic [AW-1:0] redirect_tgt_i, vbr_i;
   logic [SB_W-1:0] sb_set_i, sb_clr_i;
   logic [AW-1:0] fip_o, nip_o, xip_o, sfip_o, snip_o, sxip_o;
   logic [3:0] psr_o, epsr_o;
   logic [SB_W-1:0] sb_o, ssb_o;
   logic ifault_o;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   always #2 clk = ~clk;

   ip_sequencer uut (
      .clk(clk), .rst_n(rst_n), .fetch_fault_i(fetch_fault_i), .irq_i(irq_i),
      .exc_req_i(exc_req_i), .exc_vec_i(exc_vec_i), .rte_i(rte_i),
      .redirect_i(redirect_i), .redirect_kill_i(redirect_kill_i),
      .redirect_tgt_i(redirect_tgt_i), .vbr_i(vbr_i), .sb_set_i(sb_set_i),
      .sb_clr_i(sb_clr_i), .fip_o(fip_o), .nip_o(nip_o), .xip_o(xip_o),
      .sfip_o(sfip_o), .snip_o(snip_o), .sxip_o(sxip_o), .psr_o(psr_o),
      .epsr_o(epsr_o), .sb_o(sb_o), .ssb_o(ssb_o), .ifault_o(ifault_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000 && !done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: run did not end, actual %0d cycles expected < 20000", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, got, exp);
      end
   endtask

   task automatic idle();
      fetch_fault_i = 0; irq_i = 0; exc_req_i = 0; exc_vec_i = '0; rte_i = 0;
      redirect_i = 0; redirect_kill_i = 0; redirect_tgt_i = '0; vbr_i = VBR;
      sb_set_i = '0; sb_clr_i = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      idle();
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
   endtask

   task automatic t_reset_advance();
      do_reset();
      chk("R1", "fip", fip_o, 32'h1);
      chk("R1", "nip", nip_o, 32'h0);
      chk("R1", "xip", xip_o, 32'h0);
      chk("R1", "psr", psr_o, 4'h8);
      chk("R1", "epsr", epsr_o, 4'h0);
      chk("R1", "sb", sb_o, 0);
      chk("R1", "ifault", ifault_o, 0);
      tick();
      chk("R2", "fip+4", fip_o, 32'h5);
      chk("R2", "nip", nip_o, 32'h1);
      tick();
      chk("R2", "fip", fip_o, 32'h9);
      chk("R2", "nip", nip_o, 32'h5);
      chk("R2", "xip", xip_o, 32'h1);
      chk("R3", "sfip", sfip_o, 32'h5);
      chk("R3", "snip", snip_o, 32'h1);
      chk("R3", "sxip", sxip_o, 32'h0);
   endtask

   task automatic t_fault_and_return();
      do_reset();
      sb_set_i = 32'hA5;
      tick();
      sb_set_i = '0;
      fetch_fault_i = 1;
      tick();
      fetch_fault_i = 0;
      chk("R4", "nip err", nip_o, 32'h7);
      chk("R2", "fip err cleared", fip_o, 32'h9);
      chk("R4", "ifault clean exec", ifault_o, 0);
      tick();
      chk("R4", "xip", xip_o, 32'h7);
      chk("R4", "ifault", ifault_o, 1);
      exc_req_i = 1; exc_vec_i = 9'd5;
      tick();
      exc_req_i = 0;
      chk("R4", "fault vector wins", fip_o, VBR | 32'h9);
      chk("R5", "xip invalid", xip_o, 32'h8);
      chk("R5", "nip invalid", nip_o, 32'hC);
      chk("R5", "psr", psr_o, 4'hF);
      chk("R5", "epsr", epsr_o, 4'h8);
      chk("R5", "sb cleared", sb_o, 0);
      chk("R3", "sxip captured", sxip_o, 32'h7);
      chk("R3", "snip captured", snip_o, 32'h9);
      chk("R3", "sfip captured", sfip_o, 32'hD);
      chk("R3", "ssb captured", ssb_o, 32'hA5);
      tick();
      chk("R3", "sfip frozen", sfip_o, 32'hD);
      chk("R4", "ifault after entry", ifault_o, 0);
      rte_i = 1;
      tick();
      rte_i = 0;
      chk("R7", "psr", psr_o, 4'h8);
      chk("R7", "sb", sb_o, 32'hA5);
      chk("R7", "nip err cleared", nip_o, 32'h9);
      chk("R7", "fip", fip_o, 32'hD);
      chk("R7", "xip invalid", xip_o, VBR | 32'h8);
      tick();
      chk("R7", "xip resumed", xip_o, 32'h9);
      chk("R7", "ifault", ifault_o, 0);
   endtask

   task automatic t_privilege();
      do_reset();
      rte_i = 1;
      tick();
      chk("R7", "psr from epsr", psr_o, 4'h0);
      chk("R7", "fip from shadow", fip_o, 32'h0);
      tick();
      rte_i = 0;
      chk("R8", "priv vector", fip_o, VBR | 32'h11);
      chk("R8", "psr", psr_o, 4'hF);
      chk("R8", "epsr", epsr_o, 4'h0);
   endtask

   task automatic t_interrupt();
      do_reset();
      irq_i = 1;
      tick();
      chk("R6", "irq vector", fip_o, VBR | 32'h19);
      chk("R6", "psr", psr_o, 4'hF);
      tick();
      irq_i = 0;
      chk("R6", "masked irq ignored", fip_o, VBR | 32'h1D);
      chk("R6", "epsr kept", epsr_o, 4'h8);
   endtask

   task automatic t_vector_base();
      do_reset();
      vbr_i = 32'h0002_0ABC;
      exc_req_i = 1; exc_vec_i = 9'h1FF;
      tick();
      idle();
      chk("R5", "max vector, vbr low bits masked", fip_o, 32'h0002_0FF9);
   endtask

   task automatic t_redirect();
      do_reset();
      tick();
      redirect_i = 1; redirect_tgt_i = 32'h403;
      tick();
      chk("R9", "delayed fip", fip_o, 32'h401);
      chk("R9", "delayed nip", nip_o, 32'h5);
      chk("R9", "delayed xip", xip_o, 32'h1);
      redirect_kill_i = 1; redirect_tgt_i = 32'h800;
      tick();
      idle();
      chk("R9", "kill fip", fip_o, 32'h801);
      chk("R9", "kill nip", nip_o, 32'h400);
      tick();
      chk("R9", "killed reaches exec invalid", xip_o, 32'h400);
   endtask

   initial begin
      idle();
      t_reset_advance();
      t_fault_and_return();
      t_privilege();
      t_interrupt();
      t_vector_base();
      t_redirect();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule